// File: doc/BRIEF.md
# Negative Delta-V Fast-Charge Termination Detector

This block decides when the fast-charge phase of one rechargeable cell should stop. It takes a stream of digitized open-circuit voltage readings, each marked by a valid strobe, together with a fast-charge start pulse and a slow one-second tick. It keeps the highest reading seen so far. It raises a drop flag once a reading falls a programmable number of millivolts below that peak. It raises a separate flat flag when the peak has not risen for a set number of ticks.

A hold-off window, counted in ticks from the start pulse, blocks every comparison while the cell voltage is still settling at the beginning of the charge. The upstream measurement logic presents one reading per measurement slot, which is once every 32 base timer intervals during the charge-off time. One instance serves one cell, and a two-cell charger uses two instances. The charge state machine reads the two flags and clears them with the next start pulse.

Top module: `ndv_term_detect`

## Requirements
- R1: After reset, `peak_vld_o`, `peak_o`, `drop_term_o` and `flat_term_o` are all 0, and the drop threshold holds the value 2 (codes are unsigned, 1 mV per LSB).
- R2: A strobed reading that arrives before HOLD_TICKS ticks have been counted since the last start (or since reset) leaves `peak_vld_o` and `peak_o` unchanged.
- R3: After the hold-off, the first accepted reading is loaded into `peak_o` without any comparison, and `peak_vld_o` becomes 1. Any later reading strictly above `peak_o` replaces it. Both changes are visible one cycle after the strobe.
- R4: An accepted reading for which `peak_o - code >= threshold` sets `drop_term_o` one cycle after the strobe.
- R5: `flat_term_o` rises on the cycle after the FLAT_TICKS-th tick counted with a valid peak and no peak replacement. Each replacement restarts that count from zero.
- R6: `fc_start_i` clears the peak, the valid bit, both flags, the hold-off count and the flat count on the next edge. It takes priority over a reading or a tick in the same cycle.
- R7: Once either flag is set, both flags stay set, and readings no longer change `peak_o`, until the next `fc_start_i`.
- R8: A cycle with `thr_we_i` high loads `thr_i` as the drop threshold. Neither `fc_start_i` nor any other input changes the threshold.
- R9: In a cycle where the expiring flat tick meets a reading, a reading that replaces the peak wins and no flat flag is raised. A reading that meets the drop rule sets both flags together.
- R10: A reading that arrives in the same cycle as the tick that completes the hold-off is still ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_start_i | input | 1 | Fast-charge start pulse; restarts the detector |
| tick_i | input | 1 | One-cycle pulse per second |
| smp_vld_i | input | 1 | Reading valid strobe |
| smp_code_i | input | CODE_W | Open-circuit cell voltage code, 1 mV per LSB |
| thr_we_i | input | 1 | Drop threshold write enable |
| thr_i | input | THR_W | Drop threshold value in LSBs |
| peak_o | output | CODE_W | Stored peak reading |
| peak_vld_o | output | 1 | Peak holds an accepted reading |
| drop_term_o | output | 1 | Latched voltage-drop termination |
| flat_term_o | output | 1 | Latched flat-plateau termination |

## Verification
Two functions can act in the same cycle: a reading that is being compared against the peak, and the tick that completes the flat window. The bench runs down the flat window to one tick short and then presents that tick together with a reading. In one case the reading rises above the peak, and the bench expects the peak to update and no flat flag. In the other case the reading falls by the threshold, and the bench expects both flags on the following cycle. A reading that arrives with the final hold-off tick, and a reading that arrives with a start pulse, are judged the same way against the fixed priority order.

// File: rtl/ndv_pkg.sv
package ndv_pkg;

   // verdict of one accepted reading against the stored peak
   typedef struct packed {
      logic upd;   // reading becomes the new peak
      logic drop;  // reading sits at least threshold below peak
   } ndv_verdict_t;

   // width of a counter able to hold 0..n
   function automatic int unsigned cnt_w(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((2 ** w) <= n) w++;
      return w;
   endfunction

   function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ndv_tick_timer.sv
module ndv_tick_timer #(
   parameter int unsigned LIMIT = 240
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int unsigned CW = ndv_pkg::cnt_w(LIMIT);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   generate
      if (LIMIT == 0) begin : g_zero
         // window of zero length: always expired
         logic unused_zero;
         assign unused_zero = ^{clk, rst_n, clr_i, run_i, tick_i};
         assign done_o = 1'b1;
      end else begin : g_cnt
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr_i) begin
               cnt_q <= '0;
            end else if (run_i && tick_i && (cnt_q != LIM)) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign done_o = (cnt_q == LIM);
      end
   endgenerate
endmodule

// File: rtl/ndv_thr_reg.sv
module ndv_thr_reg #(
   parameter int unsigned THR_W   = 8,
   parameter int unsigned THR_RST = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [THR_W-1:0] d_i,
   output logic [THR_W-1:0] q_o
);
   localparam logic [THR_W-1:0] RST_VAL = THR_W'(THR_RST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= RST_VAL;
      end else if (we_i) begin
         q_o <= d_i;
      end
   end
endmodule

// File: rtl/ndv_peak_hold.sv
module ndv_peak_hold #(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned THR_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 en_i,
   input  logic [CODE_W-1:0]    code_i,
   input  logic [THR_W-1:0]     thr_i,
   output logic [CODE_W-1:0]    peak_o,
   output logic                 vld_o,
   output ndv_pkg::ndv_verdict_t verdict_o
);
   localparam int unsigned CMP_W = ndv_pkg::max_w(CODE_W, THR_W);

   logic              above;
   logic [CODE_W-1:0] gap;
   logic [CMP_W-1:0]  gap_x, thr_x;

   assign above = (code_i > peak_o);
   assign gap   = peak_o - code_i;
   assign gap_x = CMP_W'(gap);
   assign thr_x = CMP_W'(thr_i);

   always_comb begin
      verdict_o.upd  = en_i && (!vld_o || above);
      verdict_o.drop = en_i && vld_o && !above && (gap_x >= thr_x);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         peak_o <= '0;
         vld_o  <= 1'b0;
      end else if (clr_i) begin
         peak_o <= '0;
         vld_o  <= 1'b0;
      end else if (verdict_o.upd) begin
         peak_o <= code_i;
         vld_o  <= 1'b1;
      end
   end
endmodule

// File: rtl/ndv_term_detect.sv
module ndv_term_detect #(
   parameter int unsigned CODE_W     = 12,
   parameter int unsigned THR_W      = 8,
   parameter int unsigned THR_RST    = 2,
   parameter int unsigned HOLD_TICKS = 240,
   parameter int unsigned FLAT_TICKS = 960
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fc_start_i,
   input  logic              tick_i,
   input  logic              smp_vld_i,
   input  logic [CODE_W-1:0] smp_code_i,
   input  logic              thr_we_i,
   input  logic [THR_W-1:0]  thr_i,
   output logic [CODE_W-1:0] peak_o,
   output logic              peak_vld_o,
   output logic              drop_term_o,
   output logic              flat_term_o
);
   generate
      if (CODE_W < 4 || CODE_W > 24) begin : g_bad_code_w
         $error("ndv_term_detect: CODE_W out of range 4..24");
      end
      if (THR_W < 1 || THR_W > CODE_W) begin : g_bad_thr_w
         $error("ndv_term_detect: THR_W must be 1..CODE_W");
      end
      if (THR_RST >= (2 ** THR_W)) begin : g_bad_thr_rst
         $error("ndv_term_detect: THR_RST does not fit THR_W");
      end
      if (FLAT_TICKS == 0) begin : g_bad_flat
         $error("ndv_term_detect: FLAT_TICKS must be nonzero");
      end
   endgenerate

   logic                  armed;
   logic                  frozen;
   logic                  accept;
   logic                  flat_run;
   logic                  flat_clr;
   logic                  drop_q;
   logic                  flat_done;
   logic [THR_W-1:0]      thr_q;
   ndv_pkg::ndv_verdict_t verdict;

   ndv_thr_reg #(.THR_W(THR_W), .THR_RST(THR_RST)) u_thr (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (thr_we_i),
      .d_i   (thr_i),
      .q_o   (thr_q)
   );

   // hold-off window, counted from start
   ndv_tick_timer #(.LIMIT(HOLD_TICKS)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (fc_start_i),
      .run_i  (1'b1),
      .tick_i (tick_i),
      .done_o (armed)
   );

   assign frozen = drop_q || flat_done;
   assign accept = smp_vld_i && armed && !frozen && !fc_start_i;

   ndv_peak_hold #(.CODE_W(CODE_W), .THR_W(THR_W)) u_peak (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (fc_start_i),
      .en_i      (accept),
      .code_i    (smp_code_i),
      .thr_i     (thr_q),
      .peak_o    (peak_o),
      .vld_o     (peak_vld_o),
      .verdict_o (verdict)
   );

   // flat window, restarted by every peak replacement
   assign flat_clr = fc_start_i || verdict.upd;
   assign flat_run = armed && peak_vld_o && !frozen;

   ndv_tick_timer #(.LIMIT(FLAT_TICKS)) u_flat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (flat_clr),
      .run_i  (flat_run),
      .tick_i (tick_i),
      .done_o (flat_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drop_q <= 1'b0;
      end else if (fc_start_i) begin
         drop_q <= 1'b0;
      end else if (verdict.drop) begin
         drop_q <= 1'b1;
      end
   end

   assign drop_term_o = drop_q;
   assign flat_term_o = flat_done;
endmodule

// File: rtl/ndv_term_detect_chk.sv
module ndv_term_detect_chk #(
   parameter int unsigned CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fc_start_i,
   input logic              tick_i,
   input logic              smp_vld_i,
   input logic              armed,
   input logic [CODE_W-1:0] peak_o,
   input logic              peak_vld_o,
   input logic              drop_term_o,
   input logic              flat_term_o
);
   // R6: start clears peak and both flags
   a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fc_start_i |=> (!peak_vld_o && !drop_term_o && !flat_term_o));

   // R3: without a start, the peak never decreases
   a_r3_peak_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (peak_vld_o && !fc_start_i) |=> (peak_vld_o && (peak_o >= $past(peak_o))));

   // R2: readings inside the hold-off do not load a peak
   a_r2_holdoff_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !peak_vld_o && !fc_start_i) |=> !peak_vld_o);

   // R7: flags are sticky until start
   a_r7_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_term_o && !fc_start_i) |=> drop_term_o);

   a_r7_flat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flat_term_o && !fc_start_i) |=> flat_term_o);

   // R7: peak frozen while terminated
   a_r7_peak_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ((drop_term_o || flat_term_o) && !fc_start_i) |=> $stable(peak_o));

   // R4: a drop needs a stored peak and a reading
   a_r4_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drop_term_o) |-> ($past(peak_vld_o) && $past(smp_vld_i)));

   // R5: the flat flag rises only on a tick
   a_r5_flat_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flat_term_o) |-> ($past(tick_i) && $past(peak_vld_o)));
endmodule

bind ndv_term_detect ndv_term_detect_chk #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fc_start_i  (fc_start_i),
   .tick_i      (tick_i),
   .smp_vld_i   (smp_vld_i),
   .armed       (armed),
   .peak_o      (peak_o),
   .peak_vld_o  (peak_vld_o),
   .drop_term_o (drop_term_o),
   .flat_term_o (flat_term_o)
);

// File: tb/ndv_term_detect_test.sv
`timescale 1ns/1ps
module ndv_term_detect_test;
   localparam int CW   = 12;
   localparam int TW   = 8;
   localparam int HOLD = 4;
   localparam int FLAT = 6;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          fc_start_i = 0, tick_i = 0, smp_vld_i = 0, thr_we_i = 0;
   logic [CW-1:0] smp_code_i = '0;
   logic [TW-1:0] thr_i = '0;
   logic [CW-1:0] peak_o;
   logic          peak_vld_o, drop_term_o, flat_term_o;

   always #4 clk = ~clk;  // 125 MHz

   ndv_term_detect #(.CODE_W(CW), .THR_W(TW), .THR_RST(2),
                     .HOLD_TICKS(HOLD), .FLAT_TICKS(FLAT)) uut (
      .clk(clk), .rst_n(rst_n), .fc_start_i(fc_start_i), .tick_i(tick_i),
      .smp_vld_i(smp_vld_i), .smp_code_i(smp_code_i), .thr_we_i(thr_we_i),
      .thr_i(thr_i), .peak_o(peak_o), .peak_vld_o(peak_vld_o),
      .drop_term_o(drop_term_o), .flat_term_o(flat_term_o));

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model state
   int m_hold, m_flat, m_peak, m_thr;
   bit m_vld, m_drop, m_flatf;

   task automatic model_reset();
      m_hold = 0; m_flat = 0; m_peak = 0; m_vld = 0;
      m_drop = 0; m_flatf = 0; m_thr = 2;
   endtask

   task automatic model_edge(bit s, bit t, bit v, int c);
      bit armed_o, frozen, upd, dr, run;
      if (s) begin
         m_hold = 0; m_flat = 0; m_peak = 0; m_vld = 0; m_drop = 0; m_flatf = 0;
         return;
      end
      armed_o = (m_hold >= HOLD);
      frozen  = m_drop || m_flatf;
      upd = 0; dr = 0;
      if (v && armed_o && !frozen) begin
         if (!m_vld || c > m_peak) upd = 1;
         else if (m_peak - c >= m_thr) dr = 1;
      end
      run = armed_o && m_vld && !frozen;
      if (t && m_hold < HOLD) m_hold++;
      if (upd) m_flat = 0;
      else if (run && t && m_flat < FLAT) m_flat++;
      if (upd) begin m_peak = c; m_vld = 1; end
      if (dr) m_drop = 1;
      m_flatf = (m_flat == FLAT);
   endtask

   // one edge with the given inputs, then an idle edge; outputs then settled
   task automatic step(bit s, bit t, bit v, int c);
      @(negedge clk);
      fc_start_i = s; tick_i = t; smp_vld_i = v; smp_code_i = CW'(c);
      model_edge(s, t, v, c);
      @(negedge clk);
      fc_start_i = 0; tick_i = 0; smp_vld_i = 0;
      model_edge(0, 0, 0, 0);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) step(0, 1, 0, 0);
   endtask

   task automatic wr_thr(int v);
      @(negedge clk);
      thr_we_i = 1; thr_i = TW'(v);
      @(negedge clk);
      thr_we_i = 0;
      m_thr = v;
   endtask

   task automatic chk1(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_out(string req, bit vld, int pk, bit dr, bit fl);
      chk1(req, "peak_vld", peak_vld_o, vld);
      chk1(req, "peak", peak_o, pk);
      chk1(req, "drop", drop_term_o, dr);
      chk1(req, "flat", flat_term_o, fl);
   endtask

   task automatic expect_model(string req);
      expect_out(req, m_vld, m_peak, m_drop, m_flatf);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      expect_out("R1", 0, 0, 0, 0);

      // R2: readings during hold-off ignored
      step(0, 0, 1, 1000);
      expect_out("R2", 0, 0, 0, 0);
      ticks(HOLD - 1);
      step(0, 0, 1, 1000);
      expect_out("R2", 0, 0, 0, 0);
      // R10: reading with final hold-off tick ignored
      step(0, 1, 1, 1000);
      expect_out("R10", 0, 0, 0, 0);
      // R3: first reading loads, larger replaces
      step(0, 0, 1, 1000);
      expect_out("R3", 1, 1000, 0, 0);
      step(0, 0, 1, 1010);
      expect_out("R3", 1, 1010, 0, 0);
      // R1/R4: default threshold 2, drop of 1 is not enough
      step(0, 0, 1, 1009);
      expect_out("R1", 1, 1010, 0, 0);
      step(0, 0, 1, 1008);
      expect_out("R4", 1, 1010, 1, 0);
      // R7: frozen after termination
      step(0, 0, 1, 1200);
      expect_out("R7", 1, 1010, 1, 0);
      ticks(FLAT + 1);
      expect_out("R7", 1, 1010, 1, 0);
      // R6: start with reading and tick in same cycle
      step(1, 1, 1, 1500);
      expect_out("R6", 0, 0, 0, 0);

      // R5: flat window, restarted by an update
      ticks(HOLD);
      step(0, 0, 1, 900);
      ticks(FLAT - 1);
      expect_out("R5", 1, 900, 0, 0);
      step(0, 0, 1, 905);
      ticks(FLAT - 1);
      expect_out("R5", 1, 905, 0, 0);
      ticks(1);
      expect_out("R5", 1, 905, 0, 1);
      step(0, 0, 1, 800);
      expect_out("R7", 1, 905, 0, 1);

      // R9: update meets expiring tick -> update wins
      step(1, 0, 0, 0);
      ticks(HOLD);
      step(0, 0, 1, 900);
      ticks(FLAT - 1);
      step(0, 1, 1, 901);
      expect_out("R9", 1, 901, 0, 0);
      // R9: drop meets expiring tick -> both flags
      ticks(FLAT - 1);
      step(0, 1, 1, 898);
      expect_out("R9", 1, 901, 1, 1);

      // R8: threshold write survives start
      wr_thr(10);
      step(1, 0, 0, 0);
      ticks(HOLD);
      step(0, 0, 1, 500);
      step(0, 0, 1, 491);
      expect_out("R8", 1, 500, 0, 0);
      step(0, 0, 1, 490);
      expect_out("R8", 1, 500, 1, 0);

      // random sessions checked against the model
      void'($urandom(32'd2024));
      for (int s = 0; s < 12; s++) begin
         int code;
         wr_thr(1 + ($urandom % 5));
         step(1, 0, 0, 0);
         expect_model("R6");
         code = 1000 + ($urandom % 400);
         for (int k = 0; k < 80; k++) begin
            bit t, v;
            t = ($urandom % 3) == 0;
            v = ($urandom % 2) == 0;
            if (k < 30) code = code + ($urandom % 6) - 1;
            else        code = code + ($urandom % 5) - 3;
            if (code < 0) code = 0;
            if (code > 4095) code = 4095;
            step(0, t, v, code);
            expect_model("R3 R4 R5");
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule